// File: doc/BRIEF.md
# Bang-Bang PLL Proportional-Integral Loop Filter

This block turns the signed word from a bang-bang phase detector into the control code of a digitally controlled oscillator (DCO). It sits between the phase detector and the DCO of an all-digital PLL. An external sequencer drives its mode, capture, preload and shift-amount inputs. All arithmetic is 26-bit two's complement. The output code is the sum of the integrator register and a proportional term, and it is refreshed on each cycle in which the reference enable is high.

In acquisition mode the integrator stops accumulating and keeps its current value. The proportional term is then the phase error, arithmetically shifted right by a programmable amount of 0 to 3, which gives a gain of 2^0 down to 2^-3. In tracking mode there are no multipliers. The sign bit of the phase error selects either plus or minus a gain magnitude, beta for the proportional path and alpha for the integrator step.

A capture strobe copies the current output code into a holding register. A preload strobe copies that holding register into the integrator, so that the integrator starts from the settled code when the loop changes mode. Integrator and output sums clamp at the signed 26-bit limits.

Top module: `bbpll_loop_filter`

## Requirements
- R1: After the asynchronous active-low reset, `dco_code`, the integrator and the holding register are all zero.
- R2: With `track_mode`=0, each cycle with `ref_en`=1 sets `dco_code` to the integrator value plus the shifted phase error, and the integrator keeps its value.
- R3: In acquisition mode the proportional term is `phase_err` sign-extended and arithmetically shifted right by `acq_shift` (0 to 3), with rounding toward minus infinity.
- R4: With `track_mode`=1 the proportional term is -`beta` when `phase_err` bit 7 is 1 and +`beta` when it is 0. `alpha` and `beta` are non-negative magnitudes with bit 25 clear.
- R5: With `track_mode`=1 and `ref_en`=1, the integrator steps by -`alpha` when `phase_err` bit 7 is 1 and by +`alpha` when it is 0. `dco_code` becomes the new integrator value plus the proportional term.
- R6: Integrator steps saturate at +2^25-1 and -2^25 instead of wrapping.
- R7: The output sum of integrator and proportional term saturates at the same limits.
- R8: `store_req`=1 copies the `dco_code` present before that edge into the holding register, in any cycle.
- R9: `load_req`=1 copies the holding register into the integrator. The value appears in `dco_code` at the next enabled update.
- R10: When `load_req` and an accumulation fall in the same cycle, the load wins and that cycle's alpha step is dropped.
- R11: In cycles with `ref_en`=0, `dco_code` and the integrator do not change, apart from a preload.
- R12: `sync_clr`=1 clears `dco_code`, the integrator and the holding register at the next edge, and overrides every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of all registers |
| ref_en | input | 1 | Reference-rate update enable |
| track_mode | input | 1 | 0 acquisition (proportional only), 1 tracking (integrator on) |
| phase_err | input | 8 | Signed phase-detector word; bit 7 is the sign |
| acq_shift | input | 2 | Right-shift amount for acquisition mode |
| alpha | input | 26 | Integrator step magnitude |
| beta | input | 26 | Tracking proportional magnitude |
| store_req | input | 1 | Capture `dco_code` into the holding register |
| load_req | input | 1 | Copy the holding register into the integrator |
| dco_code | output | 26 | Signed DCO control code |

## Verification
Every result is due one clock edge after its stimulus. `dco_code`, the integrator and the holding register are each a single register stage. A captured code reaches `dco_code` only after a preload and then an enabled update. The bench drives inputs on the falling edge. A behavioural model advances on each rising edge, and the model is compared with `dco_code` on the next falling edge, so every cycle is checked at the point where its result is settled. Hidden state such as the holding register and the integrator is exposed through preload sequences followed by acquisition updates with zero phase error.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int LF_DW  = 26;
  localparam int LF_PEW = 8;
  localparam int LF_SHW = 2;

  typedef enum logic {
    MODE_ACQ   = 1'b0,
    MODE_TRACK = 1'b1
  } lf_mode_e;
endpackage

// File: rtl/lf_sat_add.sv
module lf_sat_add #(
  parameter int DW = lf_pkg::LF_DW
) (
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] y_o
);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW:0] wide;

  always_comb begin
    wide = {a_i[DW-1], a_i} + {b_i[DW-1], b_i};
    if (wide[DW] != wide[DW-1]) begin
      y_o = wide[DW] ? MINV : MAXV;
    end else begin
      y_o = wide[DW-1:0];
    end
  end
endmodule

// File: rtl/lf_prop_path.sv
module lf_prop_path #(
  parameter int DW  = lf_pkg::LF_DW,
  parameter int PEW = lf_pkg::LF_PEW,
  parameter int SHW = lf_pkg::LF_SHW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  lf_pkg::lf_mode_e      mode_i,
  input  logic [PEW-1:0]        err_i,
  input  logic [SHW-1:0]        shift_i,
  input  logic [DW-1:0]         beta_i,
  output logic signed [DW-1:0]  prop_o,
  output logic                  err_neg_o
);
  localparam int SB = PEW - 1;

  logic signed [DW-1:0] err_ext;
  logic signed [DW-1:0] acq_term;
  logic signed [DW-1:0] trk_term;

  always_comb begin
    err_neg_o = err_i[SB];
    err_ext   = {{(DW-PEW){err_i[SB]}}, err_i};
    acq_term  = err_ext >>> shift_i;
    trk_term  = err_neg_o ? -$signed(beta_i) : $signed(beta_i);
    prop_o    = (mode_i == lf_pkg::MODE_TRACK) ? trk_term : acq_term;
  end

  // R4: with a non-zero magnitude the tracking term carries the error's sign
  p_track_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == lf_pkg::MODE_TRACK && beta_i != '0 && !beta_i[DW-1])
      |-> (prop_o[DW-1] == err_i[SB]))
    else $error("tracking proportional sign wrong");

  // R3: acquisition term never exceeds the error magnitude and keeps its sign
  p_acq_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == lf_pkg::MODE_ACQ) |-> (prop_o[DW-1] == err_i[SB]))
    else $error("acquisition term sign wrong");
endmodule

// File: rtl/lf_integrator.sv
module lf_integrator #(
  parameter int DW = lf_pkg::LF_DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic                 accum_on_i,
  input  logic                 step_neg_i,
  input  logic [DW-1:0]        alpha_i,
  input  logic                 load_i,
  input  logic signed [DW-1:0] load_val_i,
  output logic signed [DW-1:0] integ_d_o,
  output logic signed [DW-1:0] integ_q_o
);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] step;
  logic signed [DW-1:0] summed;

  always_comb begin
    step = step_neg_i ? -$signed(alpha_i) : $signed(alpha_i);
  end

  lf_sat_add #(.DW(DW)) u_acc_add (
    .a_i (integ_q_o),
    .b_i (step),
    .y_o (summed)
  );

  always_comb begin
    if (clr_i) begin
      integ_d_o = '0;
    end else if (load_i) begin
      integ_d_o = load_val_i;
    end else if (en_i && accum_on_i) begin
      integ_d_o = summed;
    end else begin
      integ_d_o = integ_q_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q_o <= '0;
    end else begin
      integ_q_o <= integ_d_o;
    end
  end

  // R11: no enable, no load, no clear -> integrator holds
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_i && !clr_i) |=> $stable(integ_q_o))
    else $error("integrator moved without enable");

  // R2: acquisition updates leave the integrator alone
  p_acq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !accum_on_i && !load_i && !clr_i) |=> $stable(integ_q_o))
    else $error("integrator moved in acquisition");

  // R9/R10: a load wins over accumulation
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> (integ_q_o == $past(load_val_i)))
    else $error("load did not reach integrator");

  // R6: upward steps at the top limit stay there
  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && accum_on_i && !step_neg_i && !alpha_i[DW-1] && !load_i && !clr_i
      && integ_q_o == MAXV) |=> (integ_q_o == MAXV))
    else $error("integrator wrapped at top");

  // R6: downward steps at the bottom limit stay there
  p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && accum_on_i && step_neg_i && !alpha_i[DW-1] && !load_i && !clr_i
      && integ_q_o == MINV) |=> (integ_q_o == MINV))
    else $error("integrator wrapped at bottom");
endmodule

// File: rtl/bbpll_loop_filter.sv
module bbpll_loop_filter #(
  parameter int DW  = lf_pkg::LF_DW,
  parameter int PEW = lf_pkg::LF_PEW,
  parameter int SHW = lf_pkg::LF_SHW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_clr,
  input  logic           ref_en,
  input  logic           track_mode,
  input  logic [PEW-1:0] phase_err,
  input  logic [SHW-1:0] acq_shift,
  input  logic [DW-1:0]  alpha,
  input  logic [DW-1:0]  beta,
  input  logic           store_req,
  input  logic           load_req,
  output logic [DW-1:0]  dco_code
);
  lf_pkg::lf_mode_e     mode;
  logic signed [DW-1:0] prop;
  logic                 err_neg;
  logic signed [DW-1:0] integ_d;
  logic signed [DW-1:0] integ_q;
  logic signed [DW-1:0] out_sum;
  logic signed [DW-1:0] dco_q;
  logic signed [DW-1:0] dco_d;
  logic signed [DW-1:0] hold_q;
  logic signed [DW-1:0] hold_d;

  always_comb begin
    mode = track_mode ? lf_pkg::MODE_TRACK : lf_pkg::MODE_ACQ;
  end

  lf_prop_path #(.DW(DW), .PEW(PEW), .SHW(SHW)) u_prop (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .err_i     (phase_err),
    .shift_i   (acq_shift),
    .beta_i    (beta),
    .prop_o    (prop),
    .err_neg_o (err_neg)
  );

  lf_integrator #(.DW(DW)) u_integ (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (sync_clr),
    .en_i       (ref_en),
    .accum_on_i (mode == lf_pkg::MODE_TRACK),
    .step_neg_i (err_neg),
    .alpha_i    (alpha),
    .load_i     (load_req),
    .load_val_i (hold_q),
    .integ_d_o  (integ_d),
    .integ_q_o  (integ_q)
  );

  lf_sat_add #(.DW(DW)) u_out_add (
    .a_i (integ_d),
    .b_i (prop),
    .y_o (out_sum)
  );

  always_comb begin
    if (sync_clr) begin
      dco_d  = '0;
      hold_d = '0;
    end else begin
      dco_d  = ref_en ? out_sum : dco_q;
      hold_d = store_req ? dco_q : hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dco_q  <= '0;
      hold_q <= '0;
    end else begin
      dco_q  <= dco_d;
      hold_q <= hold_d;
    end
  end

  assign dco_code = dco_q;

  // R12: synchronous clear empties every register
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (dco_q == '0 && hold_q == '0 && integ_q == '0))
    else $error("sync clear incomplete");

  // R8: capture takes the code present before the edge
  p_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && !sync_clr) |=> (hold_q == $past(dco_q)))
    else $error("capture mismatch");

  // R11: output stands still without an enable
  p_out_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_en && !sync_clr) |=> $stable(dco_q))
    else $error("output moved without enable");
endmodule

// File: tb/bbpll_loop_filter_test.sv
module bbpll_loop_filter_test;
  localparam int DW = 26;
  localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (DW-1));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_clr = 1'b0;
  logic          ref_en = 1'b0;
  logic          track_mode = 1'b0;
  logic [7:0]    phase_err = '0;
  logic [1:0]    acq_shift = '0;
  logic [DW-1:0] alpha = '0;
  logic [DW-1:0] beta = '0;
  logic          store_req = 1'b0;
  logic          load_req = 1'b0;
  logic [DW-1:0] dco_code;

  int     n_run = 0;
  int     n_fail = 0;
  string  tag = "R1";
  longint m_int = 0, m_hold = 0, m_dco = 0;
  logic   model_on = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bbpll_loop_filter uut (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .ref_en(ref_en),
    .track_mode(track_mode), .phase_err(phase_err), .acq_shift(acq_shift),
    .alpha(alpha), .beta(beta), .store_req(store_req), .load_req(load_req),
    .dco_code(dco_code)
  );

  function automatic longint clamp(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  // Behavioural reference, one step per rising edge
  always @(posedge clk) begin
    if (model_on) begin
      longint pe, p, ni, nh, nd;
      pe = longint'($signed(phase_err));
      nh = store_req ? m_dco : m_hold;
      if (load_req) ni = m_hold;
      else if (ref_en && track_mode)
        ni = clamp(m_int + (phase_err[7] ? -longint'(alpha) : longint'(alpha)));
      else ni = m_int;
      p = track_mode ? (phase_err[7] ? -longint'(beta) : longint'(beta))
                     : (pe >>> acq_shift);
      nd = ref_en ? clamp(ni + p) : m_dco;
      if (sync_clr) begin ni = 0; nh = 0; nd = 0; end
      m_int = ni; m_hold = nh; m_dco = nd;
    end
  end

  task automatic check_out();
    longint got;
    got = longint'($signed(dco_code));
    n_run++;
    if (got !== m_dco) begin
      n_fail++;
      $display("FAIL %s dco_code actual=%0d expected=%0d", tag, got, m_dco);
    end
  endtask

  // compare on every falling edge once the model runs
  always @(negedge clk) if (model_on) check_out();

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive_rand(int n, logic en_all);
    for (int i = 0; i < n; i++) begin
      phase_err = 8'($urandom);
      ref_en = en_all ? 1'b1 : 1'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    #1;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
    // R1: reset state
    tag = "R1";
    n_run++;
    if (dco_code !== '0) begin
      n_fail++;
      $display("FAIL R1 reset dco_code actual=%0d expected=0", dco_code);
    end
    model_on = 1'b1;

    // R2 / R3: acquisition with every shift amount
    track_mode = 1'b0;
    for (int s = 0; s < 4; s++) begin
      tag = (s == 0) ? "R2" : "R3";
      acq_shift = 2'(s);
      drive_rand(40, 1'b1);
    end

    // R11: sparse enables
    tag = "R11";
    drive_rand(60, 1'b0);

    // R4 / R5: tracking, small gains
    track_mode = 1'b1; alpha = 26'd5; beta = 26'd40;
    tag = "R4"; drive_rand(60, 1'b1);
    tag = "R5"; drive_rand(60, 1'b0);

    // R8 / R9: capture then preload, observe in acquisition with zero error
    tag = "R8";
    ref_en = 1'b0; store_req = 1'b1; step(1); store_req = 1'b0;
    tag = "R9";
    track_mode = 1'b0; acq_shift = 2'd0; phase_err = 8'd0;
    ref_en = 1'b1; step(10);
    load_req = 1'b1; ref_en = 1'b0; step(1); load_req = 1'b0;
    ref_en = 1'b1; step(3);

    // R10: preload coincides with an accumulation
    tag = "R10";
    track_mode = 1'b1; phase_err = 8'h10; step(5);
    load_req = 1'b1; step(1); load_req = 1'b0;
    store_req = 1'b1; step(1); store_req = 1'b0;
    drive_rand(10, 1'b1);
    load_req = 1'b1; phase_err = 8'h90; step(1); load_req = 1'b0; step(2);

    // R6: drive integrator into both limits
    tag = "R6";
    alpha = 26'h0FF_FFFF; beta = 26'd0;
    phase_err = 8'h05; step(8);
    phase_err = 8'hF0; step(16);

    // R7: output sum clamps while integrator sits at a limit
    tag = "R7";
    beta = 26'h1FF_FFFF;
    phase_err = 8'h7F; step(6);
    phase_err = 8'h80; step(6);
    drive_rand(20, 1'b1);

    // R12: synchronous clear mid-run with strobes active
    tag = "R12";
    store_req = 1'b1; load_req = 1'b1; sync_clr = 1'b1; step(1);
    sync_clr = 1'b0; store_req = 1'b0; load_req = 1'b0;
    alpha = 26'd3; beta = 26'd7;
    drive_rand(30, 1'b0);

    model_on = 1'b0;
    step(1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule